// File: doc/BRIEF.md
# AHB-Lite Slave with Wait States and Protection Errors

This block is the bus-facing end of a small word-addressed register array on an AHB-Lite bus. It recognises a transfer in the address phase and records what the data phase will need: the word index, the byte lanes, the direction and whether the access is legal. It then stretches the data phase by a fixed number of wait cycles. After those cycles it either completes with a single OKAY cycle or runs the two-cycle ERROR handshake. The two-cycle form gives the master one cycle to withdraw the transfer it has already pipelined behind the failing one.

Three kinds of access are refused with ERROR. The first is a write that falls inside a read-only byte window. The second is an access at or above the end of the implemented array. The third is an access whose size is wider than the data bus or whose address is not aligned to its size. A refused write leaves the array untouched. Reads of the read-only window are legal. The wait count, the array depth, the data width and the window bounds are all parameters.

Top module: `ahb_resp_slave`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, HREADYOUT is 1 and HRESP is 0. Every word of the array reads back as zero after reset.
- R2: A transfer is taken only at a rising clock edge where HSEL=1, HREADY=1 and HTRANS[1]=1 (NONSEQ=2'b10 or SEQ=2'b11). IDLE (2'b00) and BUSY (2'b01) cycles, and cycles with HSEL=0, get HREADYOUT=1 and HRESP=0 in the next cycle, and they never modify the array.
- R3: Every transfer that is taken begins its data phase with exactly WAIT_STATES cycles of HREADYOUT=0 and HRESP=0 (OKAY is encoded as 0). The default WAIT_STATES of 2 stays within the bound of 16.
- R4: A legal transfer ends with one cycle of HREADYOUT=1 and HRESP=0 right after its wait cycles. For a read, HRDATA carries the addressed word in that cycle.
- R5: A refused transfer ends with HRESP=1 (ERROR) and HREADYOUT=0 for one cycle, right after its wait cycles. This is followed by exactly one cycle of HRESP=1 and HREADYOUT=1.
- R6: A write whose byte address lies in [RO_BASE, RO_LIMIT] (inclusive; default 0x20 to 0x2F) is refused as in R5, and the addressed word keeps its old value.
- R7: Any access whose byte address is WORDS*DATA_W/8 (0x40 by default) or above is refused as in R5, for both reads and writes.
- R8: An access is refused as in R5 if HSIZE is greater than log2(DATA_W/8), or if its address is not a multiple of 2^HSIZE bytes.
- R9: Write data is taken from HWDATA in the completing cycle of the data phase. Only the lanes selected by HSIZE (0 = byte, 1 = halfword, 2 = word) and by the low address bits are written, with byte n of a word on HWDATA[8n+7:8n] (little-endian). The other lanes keep their values, and a read always returns the whole word.
- R10: Reads inside the read-only window complete with OKAY and return the stored word.
- R11: An address phase that is presented during the last cycle of a response is taken at that cycle's edge. This holds for the OKAY cycle and for the second ERROR cycle, so back-to-back transfers lose no cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| HCLK | input | 1 | Bus clock |
| HRESETn | input | 1 | Asynchronous reset, active low |
| HSEL | input | 1 | Slave select from the address decoder |
| HADDR | input | ADDR_W | Byte address of the transfer |
| HTRANS | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| HWRITE | input | 1 | 1 for a write, 0 for a read |
| HSIZE | input | 3 | log2 of the transfer size in bytes |
| HWDATA | input | DATA_W | Write data, valid in the data phase |
| HREADY | input | 1 | Bus-wide ready; 1 marks the previous transfer as complete |
| HRDATA | output | DATA_W | Read data, valid in the OKAY completion cycle |
| HREADYOUT | output | 1 | 0 stretches the current data phase |
| HRESP | output | 1 | 0 = OKAY, 1 = ERROR |

## Verification
Word writes followed by read-back of distinct patterns show that plain storage works and that the completion comes after the right number of wait cycles. Byte and halfword writes into a word that already holds data separate correct lane steering from whole-word overwrites. Writes into the protected window, accesses past the end of the array, oversize transfers and unaligned transfers each have to produce the two-cycle ERROR. A read-back after each refused write shows whether the array was left alone. BUSY cycles, IDLE cycles and deselected NONSEQ cycles that carry write data show whether the slave ignores non-transfers. Transfers issued back to back, including one right after an ERROR, separate proper pipelining from dropped or repeated address phases.

// File: rtl/ahb_resp_slave.sv
module ahb_resp_slave #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int WORDS       = 16,
  parameter int WAIT_STATES = 2,
  parameter logic [ADDR_W-1:0] RO_BASE  = 'h20,
  parameter logic [ADDR_W-1:0] RO_LIMIT = 'h2F
) (
  input  logic              HCLK,
  input  logic              HRESETn,
  input  logic              HSEL,
  input  logic [ADDR_W-1:0] HADDR,
  input  logic [1:0]        HTRANS,
  input  logic              HWRITE,
  input  logic [2:0]        HSIZE,
  input  logic [DATA_W-1:0] HWDATA,
  input  logic              HREADY,
  output logic [DATA_W-1:0] HRDATA,
  output logic              HREADYOUT,
  output logic              HRESP
);

  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int WCNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(WORDS * LANES);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_ERR2} phase_t;

  phase_t            phase;
  logic [WCNT_W-1:0] wcnt;
  logic              err_q, wr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LANES-1:0]  strb_q, strb_d;
  logic [DATA_W-1:0] mem [WORDS];
  logic              misalign;

  wire accept   = HSEL && HREADY && HTRANS[1];
  wire last_w   = (phase == S_DATA) && (wcnt == '0);
  wire done_ok  = last_w && !err_q;
  wire can_take = (phase == S_IDLE) || (phase == S_ERR2) || done_ok;

  wire out_rng  = HADDR >= SPAN;
  wire in_ro    = (HADDR >= RO_BASE) && (HADDR <= RO_LIMIT);
  wire bad_size = int'(HSIZE) > $clog2(LANES);
  wire err_d    = out_rng || (HWRITE && in_ro) || bad_size || misalign;

  always_comb begin
    misalign = 1'b0;
    for (int k = 0; k < OFF_W; k++)
      if (k < int'(HSIZE) && HADDR[k]) misalign = 1'b1;
    for (int b = 0; b < LANES; b++)
      strb_d[b] = ((b >> HSIZE) == (int'(HADDR[OFF_W-1:0]) >> HSIZE));
  end

  always_ff @(posedge HCLK or negedge HRESETn) begin
    if (!HRESETn) begin
      phase  <= S_IDLE;
      wcnt   <= '0;
      err_q  <= 1'b0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      strb_q <= '0;
    end else if (can_take) begin
      if (accept) begin
        phase  <= S_DATA;
        wcnt   <= WCNT_W'(WAIT_STATES);
        err_q  <= err_d;
        wr_q   <= HWRITE;
        idx_q  <= HADDR[OFF_W +: IDX_W];
        strb_q <= strb_d;
      end else begin
        phase <= S_IDLE;
      end
    end else if (phase == S_DATA) begin
      if (wcnt != '0) wcnt <= wcnt - 1'b1;
      else            phase <= S_ERR2;
    end
  end

  always_ff @(posedge HCLK or negedge HRESETn) begin
    if (!HRESETn) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else if (done_ok && wr_q) begin
      for (int b = 0; b < LANES; b++)
        if (strb_q[b]) mem[idx_q][8*b +: 8] <= HWDATA[8*b +: 8];
    end
  end

  assign HREADYOUT = !((phase == S_DATA) && ((wcnt != '0) || err_q));
  assign HRESP     = (phase == S_ERR2) || (last_w && err_q);
  assign HRDATA    = (done_ok && !wr_q) ? mem[idx_q] : '0;

endmodule

// File: rtl/ahb_resp_slave_chk.sv
module ahb_resp_slave_chk #(
  parameter int WAIT_STATES = 2
) (
  input logic       HCLK,
  input logic       HRESETn,
  input logic       HSEL,
  input logic [1:0] HTRANS,
  input logic       HREADY,
  input logic       HREADYOUT,
  input logic       HRESP
);

  int run;

  always_ff @(posedge HCLK or negedge HRESETn) begin
    if (!HRESETn) run <= 0;
    else if (!HREADYOUT && !HRESP) run <= run + 1;
    else run <= 0;
  end

  always @(posedge HCLK) begin
    if (HRESETn) begin
      assert_wait_bound_R3: assert (run <= WAIT_STATES)
        else $error("wait run %0d exceeds %0d", run, WAIT_STATES);
      if ((HREADYOUT || HRESP) && run != 0)
        assert_wait_exact_R3: assert (run == WAIT_STATES)
          else $error("wait run %0d, expected %0d", run, WAIT_STATES);
    end
  end

  assert_err_second_R5: assert property (@(posedge HCLK) disable iff (!HRESETn)
    (!HREADYOUT && HRESP) |=> (HREADYOUT && HRESP));

  assert_err_paired_R5: assert property (@(posedge HCLK) disable iff (!HRESETn)
    (HREADYOUT && HRESP) |-> $past(!HREADYOUT && HRESP));

  assert_no_take_R2: assert property (@(posedge HCLK) disable iff (!HRESETn)
    (HREADY && HREADYOUT && !(HSEL && HTRANS[1])) |=> (HREADYOUT && !HRESP));

  generate
    if (WAIT_STATES > 0) begin : g_wait
      assert_wait_start_R3: assert property (@(posedge HCLK) disable iff (!HRESETn)
        (HSEL && HREADY && HTRANS[1] && HREADYOUT) |=> (!HREADYOUT && !HRESP));
    end else begin : g_nowait
      assert_no_wait_R4: assert property (@(posedge HCLK) disable iff (!HRESETn)
        (HSEL && HREADY && HTRANS[1] && HREADYOUT) |=> (HREADYOUT || HRESP));
    end
  endgenerate

endmodule

bind ahb_resp_slave ahb_resp_slave_chk #(.WAIT_STATES(WAIT_STATES)) u_chk (
  .HCLK(HCLK), .HRESETn(HRESETn), .HSEL(HSEL), .HTRANS(HTRANS),
  .HREADY(HREADY), .HREADYOUT(HREADYOUT), .HRESP(HRESP)
);

// File: tb/test_ahb_resp_slave.sv
`timescale 1ns/100ps
module test_ahb_resp_slave;

  localparam int WS = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        HSEL;
  logic [31:0] HADDR;
  logic [1:0]  HTRANS;
  logic        HWRITE;
  logic [2:0]  HSIZE;
  logic [31:0] HWDATA;
  logic [31:0] HRDATA;
  logic        HREADYOUT, HRESP, HREADY;

  assign HREADY = HREADYOUT;

  ahb_resp_slave #(.WAIT_STATES(WS)) i_ahb_resp_slave (
    .HCLK(clk), .HRESETn(rst_n), .HSEL(HSEL), .HADDR(HADDR), .HTRANS(HTRANS),
    .HWRITE(HWRITE), .HSIZE(HSIZE), .HWDATA(HWDATA), .HREADY(HREADY),
    .HRDATA(HRDATA), .HREADYOUT(HREADYOUT), .HRESP(HRESP)
  );

  always #2.5 clk = ~clk;

  typedef struct { logic err; logic rd; logic [31:0] data; string tag; } exp_t;
  exp_t        sb[$];
  logic [31:0] model [16];
  int          n_chk = 0, n_bad = 0;
  bit          in_data = 0;
  bit          finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic xfer(input logic [31:0] a, input logic w, input logic [2:0] sz,
                      input logic [31:0] wd, input string tag);
    exp_t e;
    logic [31:0] word;
    bit mis, bad;
    mis = (sz <= 2) && ((a & ((32'd1 << sz) - 1)) != 0);
    bad = (a >= 32'h40) || (w && a >= 32'h20 && a <= 32'h2F) || (sz > 2) || mis;
    e.err = bad; e.rd = !w; e.tag = tag;
    e.data = bad ? 32'h0 : model[a[5:2]];
    if (w && !bad) begin
      word = model[a[5:2]];
      for (int k = 0; k < (1 << sz); k++) begin
        int lane = int'(a[1:0]) + k;
        word[8*lane +: 8] = wd[8*lane +: 8];
      end
      model[a[5:2]] = word;
    end
    sb.push_back(e);
    HSEL = 1'b1; HTRANS = 2'b10; HADDR = a; HWRITE = w; HSIZE = sz;
    while (!HREADYOUT) @(negedge clk);
    @(negedge clk);
    HSEL = 1'b0; HTRANS = 2'b00; HWDATA = wd;
  endtask

  task automatic idle(input int n);
    HSEL = 1'b0; HTRANS = 2'b00;
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor, sampling 1 ns after the falling edge
  int waits;
  bit seen_e1;
  always begin
    @(negedge clk);
    #1;
    if (rst_n && !finished) begin
      if (in_data) begin
        if (!HREADYOUT && !HRESP) begin
          chk(!seen_e1, "R5 wait after first error cycle", {31'd0, HRESP}, 32'd1);
          waits++;
        end else if (!HREADYOUT && HRESP) begin
          chk(!seen_e1, "R5 first error cycle repeated", 32'd1, 32'd0);
          seen_e1 = 1;
        end else begin
          exp_t e;
          if (sb.size() == 0) begin
            chk(0, "R2 completion with no transfer issued", 32'd1, 32'd0);
          end else begin
            e = sb.pop_front();
            chk(waits == WS, {"R3 wait count ", e.tag}, waits, WS);
            chk(HRESP == e.err, {"R4/R5 response ", e.tag}, {31'd0, HRESP}, {31'd0, e.err});
            chk(seen_e1 == e.err, {"R5 two-cycle form ", e.tag}, {31'd0, seen_e1}, {31'd0, e.err});
            if (e.rd && !e.err) chk(HRDATA == e.data, {"R4 read data ", e.tag}, HRDATA, e.data);
          end
          in_data = 0;
        end
      end else begin
        chk(HREADYOUT && !HRESP, "R2 idle bus is zero-wait OKAY", {30'd0, HREADYOUT, HRESP}, 32'd2);
      end
      if (HSEL && HREADY && HTRANS[1]) begin
        in_data = 1; waits = 0; seen_e1 = 0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 32'h0;
    rst_n = 1'b0; HSEL = 0; HADDR = 0; HTRANS = 0; HWRITE = 0; HSIZE = 0; HWDATA = 0;
    repeat (3) @(negedge clk);
    chk(HREADYOUT && !HRESP, "R1 outputs during reset", {30'd0, HREADYOUT, HRESP}, 32'd2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(HREADYOUT && !HRESP, "R1 outputs after reset", {30'd0, HREADYOUT, HRESP}, 32'd2);

    xfer(32'h00, 0, 2, 0, "R1 reset word 0");
    xfer(32'h3C, 0, 2, 0, "R1 reset word 15");

    xfer(32'h00, 1, 2, 32'hDEADBEEF, "R4 word write");
    xfer(32'h04, 1, 2, 32'h01234567, "R11 back-to-back write");
    xfer(32'h00, 0, 2, 0, "R4 read word 0");
    xfer(32'h04, 0, 2, 0, "R11 read after write");

    xfer(32'h08, 1, 2, 32'h55667788, "R9 base word");
    xfer(32'h09, 1, 0, 32'h0000AB00, "R9 byte lane 1");
    xfer(32'h0A, 1, 1, 32'h12340000, "R9 halfword upper");
    xfer(32'h08, 0, 0, 0, "R9 whole word on byte read");

    xfer(32'h20, 0, 2, 0, "R10 read-only word before");
    xfer(32'h24, 1, 2, 32'hFFFFFFFF, "R6 write into read-only window");
    xfer(32'h24, 0, 2, 0, "R6 window word unchanged");
    xfer(32'h2F, 1, 0, 32'hAA000000, "R6 window upper byte");
    xfer(32'h30, 1, 2, 32'hCAFEF00D, "R6 just above window");
    xfer(32'h1C, 1, 2, 32'h0BADC0DE, "R6 just below window");
    xfer(32'h2C, 0, 2, 0, "R10 window read");
    xfer(32'h30, 0, 2, 0, "R6 read above window");

    xfer(32'h40, 0, 2, 0, "R7 read past end");
    xfer(32'h100, 1, 2, 32'h11111111, "R7 write past end");
    xfer(32'h3C, 1, 2, 32'h3C3C3C3C, "R11 transfer after error");
    xfer(32'h3C, 0, 2, 0, "R7 last word intact");

    xfer(32'h10, 1, 3, 32'h99999999, "R8 oversize");
    xfer(32'h12, 1, 2, 32'h77777777, "R8 misaligned word");
    xfer(32'h11, 1, 1, 32'h66666666, "R8 misaligned halfword");
    xfer(32'h10, 0, 2, 0, "R8 word untouched");

    idle(WS + 3);
    HSEL = 1; HTRANS = 2'b01; HADDR = 32'h00; HWRITE = 1; HSIZE = 2; HWDATA = 32'h5A5A5A5A;
    @(negedge clk);
    HSEL = 0; HTRANS = 2'b10;
    @(negedge clk);
    HSEL = 1; HTRANS = 2'b00;
    @(negedge clk);
    idle(2);
    xfer(32'h00, 0, 2, 0, "R2 BUSY and deselected writes ignored");

    for (int i = 0; i < 16; i++)
      if (i < 8 || i > 11) xfer(32'(i * 4), 1, 2, 32'hA5000000 ^ (32'(i) * 32'h01010101), "R4 fill");
    for (int i = 0; i < 16; i++) xfer(32'(i * 4), 0, 2, 0, "R4 sweep read");

    idle(WS + 4);
    chk(sb.size() == 0 && !in_data, "R4 all transfers completed", sb.size(), 0);
    finish_run();
  end

endmodule